// File: doc/BRIEF.md
# Packed Element Interleave Unit

This block merges two 128-bit operands, called the destination and the source, into one 128-bit result. Both operands are split into elements of a chosen size (8, 16, 32 or 64 bits). One half of each operand is then woven together: the destination element always lands in the even result lane and the matching source element in the odd lane above it. A half select picks whether the lower or the upper half of both operands feeds the result. The half that is not selected never reaches the output.

A narrow mode gives the 64-bit register behaviour for 8-, 16- and 32-bit elements. Only the selected 32-bit half of each operand's low 64 bits is read, the interleaved 64-bit value fills the low half of the result, and the upper 64 result bits are zero. A single byte-granular crossbar serves every element size, both halves and both modes. The unit is fully pipelined: it accepts one operation per cycle and returns each result exactly two cycles after issue, in issue order. A size code that is not defined for the current mode returns the destination unchanged and raises an illegal flag.

Top module: `pkd_ilv_unit`

## Requirements
- R1: With size_code 2 (32-bit), narrow 0 and sel_high 0, the result 32-bit lanes 0..3 equal dst lane 0, src lane 0, dst lane 1 and src lane 1.
- R2: With size_code 2, narrow 0 and sel_high 1, the result 32-bit lanes 0..3 equal dst lane 2, src lane 2, dst lane 3 and src lane 3.
- R3: For size_code 0 (8-bit) and 1 (16-bit) with narrow 0, the element width is W. Result lane 2k is dst element b+k and lane 2k+1 is src element b+k, where b is 0 when sel_high is 0 and 64/W when sel_high is 1.
- R4: With size_code 3 (64-bit) and narrow 0, the result is {src q, dst q}, where q is the low 64 bits of each operand when sel_high is 0 and the high 64 bits when sel_high is 1.
- R5: With narrow 1 and size_code 0, 1 or 2, the low 64 result bits interleave elements taken only from operand bits 31:0 (sel_high 0) or bits 63:32 (sel_high 1). Bytes give eight result bytes, words give four words, and doublewords give two doublewords.
- R6: With narrow 1 and a defined size code, result bits 127:64 are zero.
- R7: out_valid is high exactly two cycles after each cycle in which in_valid is high, and at no other time. One operation may be issued every cycle, and results leave in issue order.
- R8: With size_code 0 and an all-zero source, each result 16-bit word k equals the selected destination byte k zero-extended.
- R9: Size codes 4 to 7, and code 3 with narrow 1, are undefined. Such an operation returns the whole dst operand unchanged with illegal 1. illegal is 0 for defined codes and whenever out_valid is 0.
- R10: Operand bits outside the selected half have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| dst_op | input | 128 | Destination operand, supplies the even lanes |
| src_op | input | 128 | Source operand, supplies the odd lanes |
| size_code | input | 3 | Element size: 0 8-bit, 1 16-bit, 2 32-bit, 3 64-bit, others undefined |
| sel_high | input | 1 | 1 selects the upper half of each operand, 0 the lower half |
| narrow | input | 1 | 1 selects 64-bit register mode |
| out_valid | output | 1 | Result strobe, two cycles after issue |
| result | output | 128 | Interleaved result |
| illegal | output | 1 | Undefined size code for this operation, valid with out_valid |

## Verification
The assertions assume that size_code, sel_high and narrow hold known values in any cycle where in_valid is high. They also assume in_valid stays low while rst_n is asserted, and that the consumer takes a result in the cycle it appears, because the block has no back-pressure. The bench drives all inputs on the falling edge, so they are settled long before each rising edge. It keeps in_valid low throughout reset and draws size codes from the full 3-bit range, with no X or Z values. Both back-to-back issue and idle gaps appear, so the exact two-cycle spacing is checked under each pattern.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   // size code encodings
   localparam logic [2:0] SZ_BYTE  = 3'd0;
   localparam logic [2:0] SZ_WORD  = 3'd1;
   localparam logic [2:0] SZ_DWORD = 3'd2;
   localparam logic [2:0] SZ_QWORD = 3'd3;

   // per-lane crossbar control fields
   typedef struct packed {
      logic blank;    // drive lane to zero
      logic use_src;  // take lane from source operand
   } lane_flags_t;
endpackage

// File: rtl/ilv_pipe_reg.sv
module ilv_pipe_reg #(
   parameter int W          = 8,
   parameter int VW         = 1,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vld_d,
   input  logic [W-1:0]  dat_d,
   output logic [VW-1:0] vld_q,
   output logic [W-1:0]  dat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
   end

   generate
      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dat_q <= '0;
            else        dat_q <= dat_d;
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            dat_q <= dat_d;
         end
      end
   endgenerate
endmodule

// File: rtl/ilv_decode.sv
module ilv_decode
   import ilv_pkg::*;
#(
   parameter int DATA_W   = 128,
   parameter int NARROW_W = 64,
   parameter int LANE_W   = 8,
   parameter int SZ_W     = 3,
   localparam int NB      = DATA_W / LANE_W,
   localparam int NB_N    = NARROW_W / LANE_W,
   localparam int IDX_W   = $clog2(NB),
   localparam int CW      = IDX_W + 2
) (
   input  logic [SZ_W-1:0]  size_code,
   input  logic             sel_high,
   input  logic             narrow,
   output logic             legal,
   output logic [NB*CW-1:0] ctl
);
   // largest code whose element still fits twice into the operand span
   localparam int WIDE_MAX   = $clog2(NB) - 1;
   localparam int NARROW_MAX = $clog2(NB_N) - 1;

   always_comb begin
      if (narrow) legal = (int'(size_code) <= NARROW_MAX);
      else        legal = (int'(size_code) <= WIDE_MAX);
   end

   generate
      for (genvar j = 0; j < NB; j++) begin : g_lane
         localparam int J = j;
         logic [IDX_W-1:0] idx;
         lane_flags_t      fl;

         always_comb begin
            int szi;
            int base;
            int pos;
            szi  = int'(size_code);
            if (narrow) base = sel_high ? NB_N / 2 : 0;
            else        base = sel_high ? NB / 2   : 0;
            pos  = base + ((J >> (szi + 1)) << szi) + (J & ((1 << szi) - 1));
            if (legal) begin
               idx        = IDX_W'(pos);
               fl.use_src = ((J >> szi) & 1) == 1;
               fl.blank   = narrow && (J >= NB_N);
            end else begin
               idx        = IDX_W'(J);
               fl.use_src = 1'b0;
               fl.blank   = 1'b0;
            end
         end

         assign ctl[J*CW +: CW] = {fl.blank, fl.use_src, idx};
      end
   endgenerate
endmodule

// File: rtl/ilv_xbar.sv
module ilv_xbar #(
   parameter int DATA_W = 128,
   parameter int LANE_W = 8,
   localparam int NB    = DATA_W / LANE_W,
   localparam int IDX_W = $clog2(NB),
   localparam int CW    = IDX_W + 2
) (
   input  logic [DATA_W-1:0] dst_in,
   input  logic [DATA_W-1:0] src_in,
   input  logic [NB*CW-1:0]  ctl,
   output logic [DATA_W-1:0] dat_out
);
   logic [LANE_W-1:0] dst_l [NB];
   logic [LANE_W-1:0] src_l [NB];

   generate
      for (genvar i = 0; i < NB; i++) begin : g_split
         assign dst_l[i] = dst_in[i*LANE_W +: LANE_W];
         assign src_l[i] = src_in[i*LANE_W +: LANE_W];
      end

      for (genvar j = 0; j < NB; j++) begin : g_out
         logic [IDX_W-1:0] sel;
         logic             from_src;
         logic             zero;
         assign sel      = ctl[j*CW +: IDX_W];
         assign from_src = ctl[j*CW + IDX_W];
         assign zero     = ctl[j*CW + IDX_W + 1];
         always_comb begin
            if (zero)          dat_out[j*LANE_W +: LANE_W] = '0;
            else if (from_src) dat_out[j*LANE_W +: LANE_W] = src_l[sel];
            else               dat_out[j*LANE_W +: LANE_W] = dst_l[sel];
         end
      end
   endgenerate
endmodule

// File: rtl/pkd_ilv_unit.sv
module pkd_ilv_unit #(
   parameter int DATA_W     = 128,
   parameter int NARROW_W   = 64,
   parameter int LANE_W     = 8,
   parameter int SZ_W       = 3,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] dst_op,
   input  logic [DATA_W-1:0] src_op,
   input  logic [SZ_W-1:0]   size_code,
   input  logic              sel_high,
   input  logic              narrow,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);
   localparam int NB    = DATA_W / LANE_W;
   localparam int IDX_W = $clog2(NB);
   localparam int CW    = IDX_W + 2;
   localparam int S1_W  = 2 * DATA_W + NB * CW;

   // elaboration-time parameter checks
   generate
      if (DATA_W != 2 * NARROW_W) begin : g_chk_span
         $error("DATA_W must be twice NARROW_W");
      end
      if ((DATA_W % LANE_W) != 0 || (1 << IDX_W) != NB) begin : g_chk_lane
         $error("DATA_W/LANE_W must be a power of two");
      end
      if (NARROW_W < 2 * LANE_W) begin : g_chk_narrow
         $error("NARROW_W must hold at least two lanes");
      end
      if ((1 << SZ_W) <= $clog2(NB)) begin : g_chk_code
         $error("SZ_W too small to encode every element size");
      end
   endgenerate

   // stage 0: decode
   logic             legal_s0;
   logic [NB*CW-1:0] ctl_s0;

   ilv_decode #(
      .DATA_W(DATA_W), .NARROW_W(NARROW_W), .LANE_W(LANE_W), .SZ_W(SZ_W)
   ) u_dec (
      .size_code(size_code),
      .sel_high (sel_high),
      .narrow   (narrow),
      .legal    (legal_s0),
      .ctl      (ctl_s0)
   );

   // stage 1 register: operands plus lane control
   logic [1:0]       vld_s1;
   logic [S1_W-1:0]  dat_s1;

   ilv_pipe_reg #(.W(S1_W), .VW(2), .RESET_DATA(RESET_DATA)) u_s1 (
      .clk  (clk),
      .rst_n(rst_n),
      .vld_d({in_valid, in_valid & ~legal_s0}),
      .dat_d({dst_op, src_op, ctl_s0}),
      .vld_q(vld_s1),
      .dat_q(dat_s1)
   );

   // crossbar between stages
   logic [DATA_W-1:0] xb_out;

   ilv_xbar #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_xbar (
      .dst_in (dat_s1[S1_W-1 -: DATA_W]),
      .src_in (dat_s1[NB*CW +: DATA_W]),
      .ctl    (dat_s1[NB*CW-1:0]),
      .dat_out(xb_out)
   );

   // stage 2 register: result
   logic [1:0] vld_s2;

   ilv_pipe_reg #(.W(DATA_W), .VW(2), .RESET_DATA(RESET_DATA)) u_s2 (
      .clk  (clk),
      .rst_n(rst_n),
      .vld_d(vld_s1),
      .dat_d(xb_out),
      .vld_q(vld_s2),
      .dat_q(result)
   );

   assign out_valid = vld_s2[1];
   assign illegal   = vld_s2[0];
endmodule

// File: rtl/pkd_ilv_unit_chk.sv
module pkd_ilv_unit_chk #(
   parameter int DATA_W   = 128,
   parameter int NARROW_W = 64,
   parameter int LANE_W   = 8,
   parameter int SZ_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [DATA_W-1:0] dst_op,
   input logic [DATA_W-1:0] src_op,
   input logic [SZ_W-1:0]   size_code,
   input logic              sel_high,
   input logic              narrow,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              illegal
);
   localparam int HW  = DATA_W / 2;
   localparam int QW  = DATA_W / 4;
   localparam int DSZ = $clog2(QW / LANE_W);
   localparam int QSZ = $clog2(HW / LANE_W);

   logic              v1, v2, h1, h2, n1, n2;
   logic [SZ_W-1:0]   z1, z2;
   logic [DATA_W-1:0] d1, d2, s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0; v2 <= 1'b0; h1 <= 1'b0; h2 <= 1'b0; n1 <= 1'b0; n2 <= 1'b0;
         z1 <= '0; z2 <= '0; d1 <= '0; d2 <= '0; s1 <= '0; s2 <= '0;
      end else begin
         v1 <= in_valid;  v2 <= v1;
         h1 <= sel_high;  h2 <= h1;
         n1 <= narrow;    n2 <= n1;
         z1 <= size_code; z2 <= z1;
         d1 <= dst_op;    d2 <= d1;
         s1 <= src_op;    s2 <= s1;
      end
   end

   function automatic logic code_ok(logic [SZ_W-1:0] z, logic n);
      int span;
      span = n ? NARROW_W : DATA_W;
      if (int'(z) > 15) return 1'b0;
      return (2 * (LANE_W << z)) <= span;
   endfunction

   logic fmt_ok;
   assign fmt_ok = code_ok(z2, n2);

   // R7: result strobe follows issue by exactly two cycles
   a_r7_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == v2);

   // R9: flag tracks code legality
   a_r9_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (illegal == !fmt_ok));

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !illegal);

   a_r9_dst_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> (result == d2));

   // R6: narrow mode clears the upper half
   a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && n2 && fmt_ok) |-> (result[DATA_W-1:HW] == '0));

   // R1: low 32-bit interleave
   a_r1_low_dword: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !n2 && !h2 && int'(z2) == DSZ) |->
      (result == {s2[QW +: QW], d2[QW +: QW], s2[0 +: QW], d2[0 +: QW]}));

   // R2: high 32-bit interleave
   a_r2_high_dword: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !n2 && h2 && int'(z2) == DSZ) |->
      (result == {s2[3*QW +: QW], d2[3*QW +: QW], s2[2*QW +: QW], d2[2*QW +: QW]}));

   // R4: 64-bit element interleave
   a_r4_quad: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !n2 && int'(z2) == QSZ) |->
      (result == (h2 ? {s2[HW +: HW], d2[HW +: HW]} : {s2[0 +: HW], d2[0 +: HW]})));
endmodule

bind pkd_ilv_unit pkd_ilv_unit_chk #(
   .DATA_W(DATA_W), .NARROW_W(NARROW_W), .LANE_W(LANE_W), .SZ_W(SZ_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_op(dst_op), .src_op(src_op),
   .size_code(size_code), .sel_high(sel_high), .narrow(narrow),
   .out_valid(out_valid), .result(result), .illegal(illegal)
);

// File: tb/pkd_ilv_unit_test.sv
`timescale 1ns/1ps
module pkd_ilv_unit_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] dst_op = '0;
   logic [127:0] src_op = '0;
   logic [2:0]   size_code = '0;
   logic         sel_high = 1'b0;
   logic         narrow = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   pkd_ilv_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dst_op(dst_op), .src_op(src_op),
      .size_code(size_code), .sel_high(sel_high), .narrow(narrow),
      .out_valid(out_valid), .result(result), .illegal(illegal)
   );

   typedef struct {
      logic [127:0] res;
      logic         ill;
      string        req;
   } exp_t;

   exp_t sb[$];

   function automatic exp_t model(logic [127:0] d, logic [127:0] s, logic [2:0] sz,
                                  logic hi, logic nw);
      exp_t e;
      e.res = '0;
      if (sz > 3'd3 || (nw && sz == 3'd3)) begin
         e.res = d;
         e.ill = 1'b1;
      end else begin
         int ew, nres, first;
         e.ill = 1'b0;
         ew    = 8 << sz;
         nres  = (nw ? 64 : 128) / ew;
         first = hi ? nres / 2 : 0;
         for (int i = 0; i < nres; i++) begin
            int k;
            k = first + i / 2;
            for (int b = 0; b < ew; b++)
               e.res[i*ew + b] = (i % 2 == 1) ? s[k*ew + b] : d[k*ew + b];
         end
      end
      return e;
   endfunction

   task automatic issue(input logic [127:0] d, input logic [127:0] s, input logic [2:0] sz,
                        input logic hi, input logic nw, input string req);
      exp_t e;
      e = model(d, s, sz, hi, nw);
      e.req = req;
      sb.push_back(e);
      in_valid  = 1'b1;
      dst_op    = d;
      src_op    = s;
      size_code = sz;
      sel_high  = hi;
      narrow    = nw;
      @(negedge clk);
      in_valid  = 1'b0;
   endtask

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", result, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(result == e.res, e.req, result, e.res);
            check(illegal == e.ill, {e.req, " illegal flag"}, 128'(illegal), 128'(e.ill));
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [127:0] a, b, c;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(out_valid == 1'b0, "R7 reset out_valid", 128'(out_valid), '0);
      check(illegal == 1'b0, "R9 reset illegal", 128'(illegal), '0);
      check(result == '0, "R7 reset result", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      a = 128'h33333333_22222222_11111111_00000000;
      b = 128'hBBBBBBBB_AAAAAAAA_99999999_88888888;
      issue(a, b, 3'd2, 1'b0, 1'b0, "R1 low dword");
      issue(a, b, 3'd2, 1'b1, 1'b0, "R2 high dword");
      issue(rnd128(), rnd128(), 3'd0, 1'b0, 1'b0, "R3 byte low");
      issue(rnd128(), rnd128(), 3'd0, 1'b1, 1'b0, "R3 byte high");
      issue(rnd128(), rnd128(), 3'd1, 1'b0, 1'b0, "R3 word low");
      issue(rnd128(), rnd128(), 3'd1, 1'b1, 1'b0, "R3 word high");
      issue(a, b, 3'd3, 1'b0, 1'b0, "R4 qword low");
      issue(a, b, 3'd3, 1'b1, 1'b0, "R4 qword high");
      repeat (3) @(negedge clk);

      for (int sz = 0; sz < 3; sz++)
         for (int hi = 0; hi < 2; hi++) begin
            issue(rnd128(), rnd128(), 3'(sz), 1'(hi), 1'b1, "R5 R6 narrow");
            @(negedge clk);
         end

      issue(rnd128(), '0, 3'd0, 1'b0, 1'b0, "R8 zero-extend low");
      issue(rnd128(), '0, 3'd0, 1'b1, 1'b0, "R8 zero-extend high");
      issue(rnd128(), '0, 3'd0, 1'b1, 1'b1, "R8 zero-extend narrow");

      for (int sz = 4; sz < 8; sz++)
         issue(rnd128(), rnd128(), 3'(sz), 1'(sz & 1), 1'(sz >> 2 & 1), "R9 undefined code");
      issue(rnd128(), rnd128(), 3'd3, 1'b0, 1'b1, "R9 narrow qword");

      // R10: vary only the unselected half; the model result must not move
      c = rnd128();
      a = rnd128();
      issue(c, a, 3'd1, 1'b0, 1'b0, "R10 base");
      issue({~c[127:64], c[63:0]}, {~a[127:64], a[63:0]}, 3'd1, 1'b0, 1'b0, "R10 upper flipped");
      issue({c[127:64], ~c[63:0]}, {a[127:64], ~a[63:0]}, 3'd2, 1'b1, 1'b0, "R10 lower flipped");
      issue({rnd128()}, {rnd128()}, 3'd0, 1'b1, 1'b1, "R10 narrow random halves");

      // mixed stream, back-to-back and with gaps
      for (int n = 0; n < 300; n++) begin
         issue(rnd128(), rnd128(), 3'($urandom_range(0, 7)), 1'($urandom), 1'($urandom),
               "R7 mixed stream");
         if ($urandom_range(0, 3) == 0) @(negedge clk);
      end

      repeat (5) @(negedge clk);
      check(sb.size() == 0, "R7 all results returned", 128'(sb.size()), '0);
      check(out_valid == 1'b0, "R7 idle after drain", 128'(out_valid), '0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule